// File: doc/BRIEF.md
# Read-Side Width and Byte-Order Adapter

This block sits on the read side of a word-wide FIFO and feeds a consumer port whose width is fixed when the block leaves full reset. Each stored word (36 bits by default) goes out whole, as two half-words, or as four bytes. The narrow pieces come out most-significant first or least-significant first, as chosen at reset. The FIFO offers its head word on a valid signal. The adapter pops that word into a holding register and then serves it piece by piece, one piece on each accepted read. It pops the next word only on the cycle that the final piece of the current word is taken.

Reads go through an output register. The piece chosen by an accepted read appears on the output bus one clock later, right-aligned, with every bit above it zero. A partial reset empties the holding register and clears the output. It leaves the width and byte-order setting unchanged, so the FIFO can be flushed without reconfiguring the port.

Top module: `outBusMatcher`

## Requirements
- R1: With `cfgNarrow` low at full reset, each accepted read delivers the whole held word on `rdData`, and every read consumes one FIFO word.
- R2: With `cfgNarrow` and `cfgByte` high at full reset, a word is served as four 9-bit pieces on `rdData[8:0]`. Piece lane n is word bits [9n+8:9n], and `rdData[35:9]` reads zero.
- R3: With `cfgNarrow` high and `cfgByte` low at full reset, a word is served as two 18-bit pieces on `rdData[17:0]`. Lane 0 is bits [17:0], lane 1 is bits [35:18], and `rdData[35:18]` reads zero.
- R4: With `cfgBigEnd` high at full reset, the pieces of a word leave in descending lane order (highest lane first). With it low, they leave in ascending lane order.
- R5: `cfgNarrow`, `cfgByte` and `cfgBigEnd` are captured only while `rstN` is low. Changing them later, including during a partial reset, has no effect on the width or the order.
- R6: Full reset (`rstN` low) and partial reset (`partRstN` low) clear `rdData` to zero and drop `rdReady`. They discard any held word, so the next read starts at the first piece of the next FIFO word.
- R7: `fifoPop` is high only when `fifoValid` is high and either no word is held or the final piece of the held word is read in that cycle.
- R8: When the final piece is read while `fifoValid` is high, the next word is loaded on the same edge and `rdReady` stays high with no idle cycle.
- R9: A read request while `rdReady` is low changes neither `rdData` nor the piece sequence.
- R10: `rdData` changes only one cycle after an accepted read (`rdEn` and `rdReady` high) and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rstN | input | 1 | Synchronous full reset, active low; captures configuration |
| partRstN | input | 1 | Synchronous partial reset, active low; keeps configuration |
| cfgNarrow | input | 1 | Narrow port select, sampled during full reset |
| cfgByte | input | 1 | Byte (high) or half-word (low) size when narrow, sampled during full reset |
| cfgBigEnd | input | 1 | Most-significant piece first when high, sampled during full reset |
| fifoData | input | 36 | Head word offered by the FIFO |
| fifoValid | input | 1 | FIFO head word is valid |
| fifoPop | output | 1 | Removes the head word from the FIFO on this edge |
| rdEn | input | 1 | Read request from the consumer |
| rdReady | output | 1 | A held word has pieces left to read |
| rdData | output | 36 | Registered output; active piece in the low bits |

## Verification
The case that matters most is a read of the final piece of a word in the same cycle as a refill of the holding register from the FIFO. The piece must come from the old word, the new word must take its place, and `rdReady` must stay high. The bench causes this by holding `rdEn` high through runs of words while the FIFO stays non-empty. It judges each such edge by comparing the delivered piece with one computed from the word index. It also checks the expected pop on that cycle and the level of `rdReady` afterwards. Runs where the FIFO drains and then refills, and runs with irregular read requests, cover the cases where the two actions happen in different cycles.

// File: rtl/obm_pkg.sv
package obm_pkg;

  // Port width chosen at full reset
  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_HALF = 2'd1,
    MODE_BYTE = 2'd2
  } widthMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadHold;   // capture FIFO head word into holding register
    logic       takePiece;  // register the selected piece onto the output
    logic [1:0] laneSel;    // lane of the held word to present
  } strobe_t;

endpackage

// File: rtl/obmCtrl.sv
module obmCtrl
  import obm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       partRstN,
  input  logic       cfgNarrow,
  input  logic       cfgByte,
  input  logic       cfgBigEnd,
  input  logic       fifoValid,
  input  logic       rdEn,
  output logic       fifoPop,
  output logic       rdReady,
  output strobe_t    stb,
  output widthMode_e modeQ
);

  logic       bigQ;
  logic       holdValid;
  logic [1:0] pieceIdx;
  logic [1:0] lastIdx;
  logic       active;
  logic       take;
  logic       lastTake;
  logic       load;

  // Configuration is captured only while full reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (!cfgNarrow)   modeQ <= MODE_LONG;
      else if (cfgByte) modeQ <= MODE_BYTE;
      else              modeQ <= MODE_HALF;
      bigQ <= cfgBigEnd;
    end
  end

  always_comb begin
    case (modeQ)
      MODE_LONG: lastIdx = 2'd0;
      MODE_HALF: lastIdx = 2'd1;
      default:   lastIdx = 2'd3;
    endcase
  end

  assign active   = rstN && partRstN;
  assign take     = active && rdEn && holdValid;
  assign lastTake = take && (pieceIdx == lastIdx);
  assign load     = active && fifoValid && (!holdValid || lastTake);

  always_ff @(posedge clk) begin
    if (!active) begin
      holdValid <= 1'b0;
      pieceIdx  <= 2'd0;
    end else begin
      if (load)          holdValid <= 1'b1;
      else if (lastTake) holdValid <= 1'b0;
      if (lastTake)      pieceIdx  <= 2'd0;
      else if (take)     pieceIdx  <= pieceIdx + 2'd1;
    end
  end

  assign fifoPop       = load;
  assign rdReady       = holdValid;
  assign stb.loadHold  = load;
  assign stb.takePiece = take;
  assign stb.laneSel   = bigQ ? (lastIdx - pieceIdx) : pieceIdx;

endmodule

// File: rtl/obmDatapath.sv
module obmDatapath
  import obm_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              partRstN,
  input  logic [WORD_W-1:0] fifoData,
  input  strobe_t           stb,
  input  widthMode_e        modeQ,
  output logic [WORD_W-1:0] rdData
);

  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = WORD_W / 4;

  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] piece;
  logic [HALF_W-1:0] halfLane [2];
  logic [BYTE_W-1:0] byteLane [4];

  always_ff @(posedge clk) begin
    if (stb.loadHold) holdReg <= fifoData;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halfLane[h] = holdReg[h*HALF_W +: HALF_W];
  end

  for (genvar b = 0; b < 4; b++) begin : g_byte
    assign byteLane[b] = holdReg[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    case (modeQ)
      MODE_LONG: piece = holdReg;
      MODE_HALF: piece = WORD_W'(halfLane[stb.laneSel[0]]);
      default:   piece = WORD_W'(byteLane[stb.laneSel]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !partRstN) rdData <= '0;
    else if (stb.takePiece) rdData <= piece;
  end

endmodule

// File: rtl/outBusMatcher.sv
module outBusMatcher
  import obm_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              partRstN,
  input  logic              cfgNarrow,
  input  logic              cfgByte,
  input  logic              cfgBigEnd,
  input  logic [WORD_W-1:0] fifoData,
  input  logic              fifoValid,
  output logic              fifoPop,
  input  logic              rdEn,
  output logic              rdReady,
  output logic [WORD_W-1:0] rdData
);

  strobe_t    stb;
  widthMode_e cfgMode;

  obmCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .partRstN  (partRstN),
    .cfgNarrow (cfgNarrow),
    .cfgByte   (cfgByte),
    .cfgBigEnd (cfgBigEnd),
    .fifoValid (fifoValid),
    .rdEn      (rdEn),
    .fifoPop   (fifoPop),
    .rdReady   (rdReady),
    .stb       (stb),
    .modeQ     (cfgMode)
  );

  obmDatapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .partRstN (partRstN),
    .fifoData (fifoData),
    .stb      (stb),
    .modeQ    (cfgMode),
    .rdData   (rdData)
  );

endmodule

// File: rtl/outBusMatcher_chk.sv
module outBusMatcher_chk
  import obm_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              partRstN,
  input logic              fifoValid,
  input logic              fifoPop,
  input logic              rdEn,
  input logic              rdReady,
  input logic [WORD_W-1:0] rdData,
  input widthMode_e        cfgMode
);

  // R7
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> fifoValid);

  // R7
  pop_only_on_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPop && rdReady) |-> rdEn);

  // R6
  partial_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !partRstN |=> (rdData == '0 && !rdReady));

  // R3
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_HALF) |-> (rdData[WORD_W-1:WORD_W/2] == '0));

  // R2
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_BYTE) |-> (rdData[WORD_W-1:WORD_W/4] == '0));

  // R9
  idle_read_stable_chk: assert property (@(posedge clk) disable iff (!rstN || !partRstN)
    (rdEn && !rdReady) |=> $stable(rdData));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !partRstN)
    (rdReady && !rdEn) |=> rdReady);

endmodule

bind outBusMatcher outBusMatcher_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .partRstN  (partRstN),
  .fifoValid (fifoValid),
  .fifoPop   (fifoPop),
  .rdEn      (rdEn),
  .rdReady   (rdReady),
  .rdData    (rdData),
  .cfgMode   (cfgMode)
);

// File: tb/outBusMatcher_bench.sv
`timescale 1ns/1ps
module outBusMatcher_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        partRstN = 1'b1;
  logic        cfgNarrow = 1'b0;
  logic        cfgByte = 1'b0;
  logic        cfgBigEnd = 1'b0;
  logic [35:0] fifoData;
  logic        fifoValid;
  logic        fifoPop;
  logic        rdEn = 1'b0;
  logic        rdReady;
  logic [35:0] rdData;

  int fifoIdx = 0;
  int fifoLimit = 0;
  logic fifoClr = 1'b1;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  int curMode;
  bit curBig;
  int wCur;
  int pCur;
  logic [35:0] lastOut;
  bit cfgNote;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  outBusMatcher u_outBusMatcher (
    .clk(clk), .rstN(rstN), .partRstN(partRstN),
    .cfgNarrow(cfgNarrow), .cfgByte(cfgByte), .cfgBigEnd(cfgBigEnd),
    .fifoData(fifoData), .fifoValid(fifoValid), .fifoPop(fifoPop),
    .rdEn(rdEn), .rdReady(rdReady), .rdData(rdData)
  );

  function automatic logic [35:0] wordOf(input int k);
    logic [63:0] t;
    t = 64'(k + 1) * 64'h9E3779B97F4A7C15 ^ 64'h0F0F_1234_5678_9ABC;
    return t[47:12];
  endfunction

  function automatic int piecesOf(input int m);
    return (m == 0) ? 1 : ((m == 1) ? 2 : 4);
  endfunction

  function automatic logic [35:0] expPiece(input logic [35:0] w, input int m,
                                           input bit big, input int p);
    int wd;
    int n;
    int lane;
    logic [63:0] v;
    n = piecesOf(m);
    wd = 36 / n;
    lane = big ? (n - 1 - p) : p;
    v = 64'(w) >> (lane * wd);
    v = v & ((64'd1 << wd) - 64'd1);
    return v[35:0];
  endfunction

  assign fifoValid = (fifoIdx < fifoLimit);
  assign fifoData  = wordOf(fifoIdx);

  always @(posedge clk) begin
    if (fifoClr) fifoIdx <= 0;
    else if (fifoPop) fifoIdx <= fifoIdx + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock: entered and left at a falling edge
  task automatic cycle(input logic en);
    bit takeNow;
    bit lastNow;
    bit validNow;
    bit expPop;
    logic [35:0] exp;
    string tag;
    rdEn = en;
    #1;
    takeNow  = en && rdReady;
    lastNow  = takeNow && (pCur == piecesOf(curMode) - 1);
    validNow = fifoValid;
    expPop   = validNow && (!rdReady || lastNow);
    check(fifoPop == expPop, "R7", "pop strobe", 36'(fifoPop), 36'(expPop));
    @(negedge clk);
    if (takeNow) begin
      exp = expPiece(wordOf(wCur), curMode, curBig, pCur);
      if (cfgNote) tag = "R5";
      else if (curBig && curMode != 0) tag = "R4";
      else if (curMode == 0) tag = "R1";
      else if (curMode == 1) tag = "R3";
      else tag = "R2";
      check(rdData == exp, tag, "piece value", rdData, exp);
      cfgNote = 1'b0;
      lastOut = exp;
      if (lastNow) begin
        pCur = 0;
        wCur++;
        check(rdReady == validNow, "R8", "ready after final piece",
              36'(rdReady), 36'(validNow));
      end else begin
        pCur++;
      end
    end else if (en) begin
      check(rdData == lastOut, "R9", "read while not ready", rdData, lastOut);
    end else begin
      check(rdData == lastOut, "R10", "hold without read", rdData, lastOut);
    end
  endtask

  task automatic runReads(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      logic en;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (pat)
        0: en = 1'b1;
        1: en = lfsr[0];
        default: en = (i % 3) != 2;
      endcase
      cycle(en);
    end
  endtask

  task automatic fullReset(input int m, input bit big);
    rdEn = 1'b0;
    rstN = 1'b0;
    fifoClr = 1'b1;
    fifoLimit = 0;
    cfgNarrow = (m != 0);
    cfgByte = (m == 2);
    cfgBigEnd = big;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fifoClr = 1'b0;
    // configuration pins move after capture
    cfgNarrow = ~cfgNarrow;
    cfgByte = ~cfgByte;
    cfgBigEnd = ~cfgBigEnd;
    #1;
    check(rdData == '0, "R6", "output after full reset", rdData, '0);
    check(rdReady == 1'b0, "R6", "ready after full reset", 36'(rdReady), 36'(0));
    curMode = m;
    curBig = big;
    wCur = 0;
    pCur = 0;
    lastOut = '0;
    cfgNote = 1'b1;
    @(negedge clk);
  endtask

  task automatic partialReset();
    rdEn = 1'b0;
    partRstN = 1'b0;
    cfgNarrow = ~cfgNarrow;
    cfgByte = ~cfgByte;
    cfgBigEnd = ~cfgBigEnd;
    repeat (2) @(negedge clk);
    partRstN = 1'b1;
    #1;
    check(rdData == '0, "R6", "output after partial reset", rdData, '0);
    check(rdReady == 1'b0, "R6", "ready after partial reset", 36'(rdReady), 36'(0));
    wCur = fifoIdx;
    pCur = 0;
    lastOut = '0;
    cfgNote = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int cfg = 0; cfg < 6; cfg++) begin
      fullReset(cfg / 2, cfg[0]);
      fifoLimit = 5;
      runReads(30, 0);
      runReads(6, 1);
      fifoLimit = 9;
      runReads(30, 1);
      // stop mid-word, then flush
      fifoLimit = 14;
      runReads(3, 2);
      partialReset();
      runReads(25, 2);
      runReads(25, 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule